// File: doc/BRIEF.md
# Keyed power-mode and clock controller

This block manages power domains and the core clock for a small microcontroller-style subsystem. Two protected registers sit behind a simple write-only register bus: a clock-configuration register and a power-mode register. Each can change only when the write is framed by a fixed key value on a dedicated key address just before it and a second key value on another key address just after it. Any other bus write during the framing abandons the attempt.

The committed power mode selects one of five operating modes (Active, Pause, Nap, Sleep, Stop). A fixed table turns that mode into enable outputs for five domains: core, peripherals, PLL, oscillator/timers and interrupt logic. Interrupt activity returns the block to Active. Nap is left only by the timer interrupt, and a clock-source choice written earlier is applied at that moment. The same register carries a 3-bit divide select that sets a core clock-enable rate of one pulse per 2^CD cycles.

The PLL lock input halts the core clock at once when lock is lost. A one-cycle PLL interrupt pulse follows when lock comes back. The analog PLL, the oscillator and the clock gating cells sit outside this block.

Top module: `pwr_clk_ctl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge): pwr_mode is 0 (Active), dom_en is 5'b11111, cd_sel is 0, clk_src is 0 (internal) and pll_irq is 0.
- R2: Three consecutive bus writes (idle cycles with bus_wr low are allowed between them) update the power-mode register: address 3 with data 0x01, then address 4 with the new value, then address 5 with data 0xF4. The value's bits [2:0] go to cd_sel and bits [7:3] are the mode code (Active=0, Pause=1, Nap=2, Sleep=3, Stop=4). pwr_mode and cd_sel take the new value at the clock edge that samples the address-5 write.
- R3: Three consecutive bus writes store a pending clock configuration: address 0 with data 0xAA, then address 1 with the value, then address 2 with data 0x55. Storing it does not change clk_src.
- R4: Framing breaks on any of these: a wrong key value, a write to any other address between the steps, or a wrong second key. The protected register is then left unchanged and the sequencer goes back to waiting for the first key. A correct sequence right after that succeeds.
- R5: A framed power-mode write whose mode code is greater than 4 is ignored as a whole: neither pwr_mode nor cd_sel change.
- R6: dom_en bit order is {irq, osc/timers, pll, peripherals, core} (bit 4 down to bit 0). Bit i is on when i >= mode code: Active 11111, Pause 11110, Nap 11100, Sleep 11000, Stop 10000.
- R7: In Pause, Sleep or Stop, any set bit of irq_act moves pwr_mode to Active at the next clock edge, so dom_en follows after that edge. A wake takes priority over a framed power-mode write at the same edge.
- R8: In Nap, only irq_act[2] (the timer interrupt) wakes the block to Active; other interrupt bits leave it in Nap. At that wake edge, clk_src takes the decoded pending clock configuration. clk_src changes at no other time.
- R9: Clock-source decoding: 8'h03 gives 2 (external clock pin); otherwise bits [1:0]==2'b01 with bit 4 clear gives 1 (external crystal); anything else gives 0 (internal).
- R10: core_halt equals the inverse of pll_lock in the same cycle, and core_clk_en is 0 while core_halt is 1.
- R11: After pll_lock is seen falling, the first clock edge with pll_lock high raises pll_irq for exactly one cycle.
- R12: A free-running 7-bit phase counter advances each cycle and is cleared while halted. core_clk_en is 1 when the counter is a multiple of 2^cd_sel, so any 16 consecutive unhalted cycles with cd_sel=2 contain exactly 4 pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register write address |
| bus_wdata | input | 8 | Register write data |
| irq_act | input | 4 | Enabled, active interrupt lines; bit 2 is the timer |
| pll_lock | input | 1 | PLL lock status |
| dom_en | output | 5 | Domain enables {irq, osc/timers, pll, periph, core} |
| pwr_mode | output | 3 | Committed operating mode code |
| cd_sel | output | 3 | Core clock divide select |
| clk_src | output | 2 | Applied clock source (0 internal, 1 crystal, 2 pin) |
| core_halt | output | 1 | Core clock halt request |
| core_clk_en | output | 1 | Divided core clock enable pulse |
| pll_irq | output | 1 | One-cycle PLL relock interrupt |

## Verification
A sequencer left in the wrong step shows up as a later framed write either taking effect when it should not, or being lost. pwr_mode and cd_sel show this at the edge after the closing key. A wrong mode register shows on dom_en at once, and a missed or spurious wake within one edge of the interrupt. A pending clock value that is wrong stays hidden until the next timer wake from Nap, so the bench wakes from Nap after each clock write. Divider phase errors appear on core_clk_en within 2^CD cycles.

// File: rtl/pwr_clk_pkg.sv
// Shared constants for the keyed power-mode and clock controller.
// Assumes an 8-bit write bus and a 3-bit mode code carried in the register.
package pwr_clk_pkg;

    localparam int BUS_DW  = 8;
    localparam int MODE_W  = 3;
    localparam int NUM_DOM = 5;

    localparam logic [MODE_W-1:0] MODE_ACTIVE = 3'd0;
    localparam logic [MODE_W-1:0] MODE_PAUSE  = 3'd1;
    localparam logic [MODE_W-1:0] MODE_NAP    = 3'd2;
    localparam logic [MODE_W-1:0] MODE_SLEEP  = 3'd3;
    localparam logic [MODE_W-1:0] MODE_STOP   = 3'd4;

    localparam logic [1:0] SRC_INT  = 2'd0;
    localparam logic [1:0] SRC_XTAL = 2'd1;
    localparam logic [1:0] SRC_PIN  = 2'd2;

    localparam int ADR_CK_K1  = 0;
    localparam int ADR_CK_CFG = 1;
    localparam int ADR_CK_K2  = 2;
    localparam int ADR_PW_K1  = 3;
    localparam int ADR_PW_CFG = 4;
    localparam int ADR_PW_K2  = 5;

    localparam logic [BUS_DW-1:0] CK_KEY1 = 8'hAA;
    localparam logic [BUS_DW-1:0] CK_KEY2 = 8'h55;
    localparam logic [BUS_DW-1:0] PW_KEY1 = 8'h01;
    localparam logic [BUS_DW-1:0] PW_KEY2 = 8'hF4;

    typedef enum logic [1:0] {
        SEQ_WAIT_K1   = 2'd0,
        SEQ_WAIT_DATA = 2'd1,
        SEQ_WAIT_K2   = 2'd2
    } seq_state_t;

    // Maps a clock-configuration value to the clock source it selects (R9).
    function automatic logic [1:0] clk_src_decode(input logic [BUS_DW-1:0] cfg);
        if (cfg == 8'h03)
            return SRC_PIN;
        else if (cfg[1:0] == 2'b01 && !cfg[4])
            return SRC_XTAL;
        else
            return SRC_INT;
    endfunction

endpackage

// File: rtl/pcm_key_seq.sv
// Three-step key sequencer guarding one protected register.
// It watches every bus write: a first key at K1_ADDR, then the data at
// DAT_ADDR, then a second key at K2_ADDR. commit pulses combinationally
// in the cycle of the correct closing write, and commit_data holds the
// captured value. Any other write aborts back to waiting for the first key.
// Assumes one write per cycle at most.
module pcm_key_seq
    import pwr_clk_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int K1_ADDR = 0,
    parameter int DAT_ADDR = 1,
    parameter int K2_ADDR = 2,
    parameter logic [BUS_DW-1:0] K1_VAL = 8'hAA,
    parameter logic [BUS_DW-1:0] K2_VAL = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              commit,
    output logic [BUS_DW-1:0] commit_data
);

    localparam logic [ADDR_W-1:0] A_K1  = ADDR_W'(K1_ADDR);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(DAT_ADDR);
    localparam logic [ADDR_W-1:0] A_K2  = ADDR_W'(K2_ADDR);

    seq_state_t        state_q;
    logic [BUS_DW-1:0] hold_q;
    logic              hit_k1;
    logic              hit_dat;
    logic              hit_k2;

    // Classify the current write against the three expected steps.
    always_comb begin
        hit_k1  = bus_wr && bus_addr == A_K1 && bus_wdata == K1_VAL;
        hit_dat = bus_wr && bus_addr == A_DAT;
        hit_k2  = bus_wr && bus_addr == A_K2 && bus_wdata == K2_VAL;
    end

    // Advance, capture or abort the framing on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_WAIT_K1;
            hold_q  <= '0;
        end else if (bus_wr) begin
            case (state_q)
                SEQ_WAIT_K1:   state_q <= hit_k1 ? SEQ_WAIT_DATA : SEQ_WAIT_K1;
                SEQ_WAIT_DATA: begin
                    if (hit_dat) begin
                        hold_q  <= bus_wdata;
                        state_q <= SEQ_WAIT_K2;
                    end else begin
                        state_q <= SEQ_WAIT_K1;
                    end
                end
                default:       state_q <= SEQ_WAIT_K1;
            endcase
        end
    end

    // Closing key in the right step releases the captured value.
    always_comb begin
        commit      = (state_q == SEQ_WAIT_K2) && hit_k2;
        commit_data = hold_q;
    end

    // R4: a write other than the data write while awaiting data aborts.
    p_abort_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && state_q == SEQ_WAIT_DATA && bus_addr != A_DAT) |=> state_q == SEQ_WAIT_K1);

    // R4: any write in the last step, good or bad, ends the sequence.
    p_k2_returns_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && state_q == SEQ_WAIT_K2) |=> state_q == SEQ_WAIT_K1);

endmodule

// File: rtl/pcm_mode_ctl.sv
// Power-mode register, wake logic, pending clock configuration and
// domain enable decode. Takes committed values from the two key sequencers.
// Wake has priority over a same-edge power-mode commit. The pending clock
// configuration reaches clk_src only at a timer wake out of Nap.
// Assumes irq_act is already qualified by the interrupt enables.
module pcm_mode_ctl
    import pwr_clk_pkg::*;
#(
    parameter int NIRQ    = 4,
    parameter int TMR_IDX = 2,
    parameter int CD_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pw_commit,
    input  logic [BUS_DW-1:0]  pw_data,
    input  logic               ck_commit,
    input  logic [BUS_DW-1:0]  ck_data,
    input  logic [NIRQ-1:0]    irq_act,
    output logic [MODE_W-1:0]  mode,
    output logic [CD_W-1:0]    cd,
    output logic [1:0]         clk_src,
    output logic [NUM_DOM-1:0] dom_en
);

    localparam int MF_W = BUS_DW - CD_W;

    logic [MODE_W-1:0] mode_q;
    logic [CD_W-1:0]   cd_q;
    logic [1:0]        src_q;
    logic [BUS_DW-1:0] ck_cfg_q;
    logic [MF_W-1:0]   req_mode;
    logic              req_ok;
    logic              wake;

    // Split the committed power value and judge the wake condition.
    always_comb begin
        req_mode = pw_data[BUS_DW-1:CD_W];
        req_ok   = req_mode <= MF_W'(MODE_STOP);
        if (mode_q == MODE_NAP)
            wake = irq_act[TMR_IDX];
        else
            wake = (mode_q != MODE_ACTIVE) && (|irq_act);
    end

    // Mode and divide register: wake first, then legal commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_ACTIVE;
            cd_q   <= '0;
        end else if (wake) begin
            mode_q <= MODE_ACTIVE;
        end else if (pw_commit && req_ok) begin
            mode_q <= req_mode[MODE_W-1:0];
            cd_q   <= pw_data[CD_W-1:0];
        end
    end

    // Pending clock configuration and the source applied at Nap exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_cfg_q <= '0;
            src_q    <= SRC_INT;
        end else begin
            if (ck_commit)
                ck_cfg_q <= ck_data;
            if (wake && mode_q == MODE_NAP)
                src_q <= clk_src_decode(ck_cfg_q);
        end
    end

    // Domain i stays powered while its index is at or above the mode code.
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        assign dom_en[g] = int'(mode_q) <= g;
    end

    assign mode    = mode_q;
    assign cd      = cd_q;
    assign clk_src = src_q;

    // R5: the mode register never holds an unused code.
    p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q <= MODE_STOP);

    // R7: any interrupt in Pause, Sleep or Stop returns to Active.
    p_wake_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_ACTIVE && mode_q != MODE_NAP && (|irq_act)) |=> mode_q == MODE_ACTIVE);

    // R8: Nap holds without the timer interrupt or a new commit.
    p_nap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NAP && !irq_act[TMR_IDX] && !pw_commit) |=> mode_q == MODE_NAP);

    // R8: the applied source moves only at a timer wake from Nap.
    p_src_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_q == MODE_NAP && irq_act[TMR_IDX]) |=> $stable(src_q));

endmodule

// File: rtl/pcm_core_clk.sv
// Core clock halt, PLL relock interrupt and power-of-two clock-enable divider.
// The halt follows the lock input with no register. A loss of lock is
// remembered, and a one-cycle interrupt is issued once lock is seen again.
// The phase counter is cleared during the halt.
module pcm_core_clk #(
    parameter int CD_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pll_lock,
    input  logic [CD_W-1:0] cd,
    output logic            core_halt,
    output logic            core_clk_en,
    output logic            pll_irq
);

    localparam int CNT_W = (1 << CD_W) - 1;

    logic             lock_q;
    logic             pend_q;
    logic             irq_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_mask;

    // Halt immediately when lock is absent; select the divide mask.
    always_comb begin
        core_halt   = !pll_lock;
        cnt_mask    = ~({CNT_W{1'b1}} << cd);
        core_clk_en = pll_lock && ((cnt_q & cnt_mask) == '0);
    end

    // Track lock loss and issue the relock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            lock_q <= pll_lock;
            irq_q  <= pend_q && pll_lock;
            if (lock_q && !pll_lock)
                pend_q <= 1'b1;
            else if (pll_lock)
                pend_q <= 1'b0;
        end
    end

    // Free-running phase counter, cleared while halted.
    always_ff @(posedge clk) begin
        if (!rst_n || !pll_lock)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign pll_irq = irq_q;

    // R11: the relock interrupt lasts one cycle.
    p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    // R11: relock after a recorded loss raises the interrupt.
    p_relock_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && pll_lock) |=> irq_q);

    // R10: the halt leaves the phase counter at zero.
    p_halt_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_lock |=> cnt_q == '0);

endmodule

// File: rtl/pwr_clk_ctl.sv
// Top of the keyed power-mode and clock controller. Two key sequencers
// guard the clock-configuration and power-mode registers. The mode
// controller holds the mode, divide select and clock source. The core clock
// unit handles halt, relock interrupt and the divided enable.
// Assumes the bus gives at most one write per cycle, synchronous to clk.
module pwr_clk_ctl
    import pwr_clk_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int NIRQ    = 4,
    parameter int TMR_IDX = 2,
    parameter int CD_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    input  logic [NIRQ-1:0]    irq_act,
    input  logic               pll_lock,
    output logic [NUM_DOM-1:0] dom_en,
    output logic [MODE_W-1:0]  pwr_mode,
    output logic [CD_W-1:0]    cd_sel,
    output logic [1:0]         clk_src,
    output logic               core_halt,
    output logic               core_clk_en,
    output logic               pll_irq
);

    logic              ck_commit;
    logic [BUS_DW-1:0] ck_data;
    logic              pw_commit;
    logic [BUS_DW-1:0] pw_data;

    pcm_key_seq #(
        .ADDR_W(ADDR_W), .K1_ADDR(ADR_CK_K1), .DAT_ADDR(ADR_CK_CFG),
        .K2_ADDR(ADR_CK_K2), .K1_VAL(CK_KEY1), .K2_VAL(CK_KEY2)
    ) u_ck_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .commit(ck_commit), .commit_data(ck_data)
    );

    pcm_key_seq #(
        .ADDR_W(ADDR_W), .K1_ADDR(ADR_PW_K1), .DAT_ADDR(ADR_PW_CFG),
        .K2_ADDR(ADR_PW_K2), .K1_VAL(PW_KEY1), .K2_VAL(PW_KEY2)
    ) u_pw_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .commit(pw_commit), .commit_data(pw_data)
    );

    pcm_mode_ctl #(
        .NIRQ(NIRQ), .TMR_IDX(TMR_IDX), .CD_W(CD_W)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .pw_commit(pw_commit), .pw_data(pw_data),
        .ck_commit(ck_commit), .ck_data(ck_data), .irq_act(irq_act),
        .mode(pwr_mode), .cd(cd_sel), .clk_src(clk_src), .dom_en(dom_en)
    );

    pcm_core_clk #(
        .CD_W(CD_W)
    ) u_core_clk (
        .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .cd(cd_sel),
        .core_halt(core_halt), .core_clk_en(core_clk_en), .pll_irq(pll_irq)
    );

endmodule

// File: tb/pwr_clk_ctl_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural model is stepped on every rising edge and compared
// at every falling edge. Directed checks cover the requirement corners.
module pwr_clk_ctl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [3:0] irq_act = '0;
    logic       pll_lock = 1'b1;

    logic [4:0] dom_en;
    logic [2:0] pwr_mode;
    logic [2:0] cd_sel;
    logic [1:0] clk_src;
    logic       core_halt;
    logic       core_clk_en;
    logic       pll_irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwr_clk_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .irq_act(irq_act), .pll_lock(pll_lock),
        .dom_en(dom_en), .pwr_mode(pwr_mode), .cd_sel(cd_sel), .clk_src(clk_src),
        .core_halt(core_halt), .core_clk_en(core_clk_en), .pll_irq(pll_irq)
    );

    // ---------------- reference model ----------------
    int         m_mode, m_cd, m_src, m_cnt;
    int         m_stage [2];
    logic [7:0] m_hold [2];
    logic [7:0] m_cfg;
    logic       m_lock_prev, m_pend, m_irq;

    function automatic int src_of(input logic [7:0] v);
        if (v == 8'h03) return 2;
        if (v[1:0] == 2'b01 && v[4] == 1'b0) return 1;
        return 0;
    endfunction

    task automatic seq_step(input int i, input int a1, input int ad, input int a2,
                            input logic [7:0] v1, input logic [7:0] v2,
                            output bit com, output logic [7:0] dat);
        com = 0;
        dat = m_hold[i];
        if (bus_wr) begin
            if (m_stage[i] == 0) begin
                if (int'(bus_addr) == a1 && bus_wdata == v1) m_stage[i] = 1;
            end else if (m_stage[i] == 1) begin
                if (int'(bus_addr) == ad) begin
                    m_hold[i] = bus_wdata;
                    m_stage[i] = 2;
                end else m_stage[i] = 0;
            end else begin
                if (int'(bus_addr) == a2 && bus_wdata == v2) com = 1;
                m_stage[i] = 0;
            end
        end
    endtask

    always @(posedge clk) begin : model
        bit cc, pc, wk;
        logic [7:0] cdat, pdat;
        started = 1;
        if (!rst_n) begin
            m_mode = 0; m_cd = 0; m_src = 0; m_cnt = 0; m_cfg = 0;
            m_stage[0] = 0; m_stage[1] = 0; m_hold[0] = 0; m_hold[1] = 0;
            m_lock_prev = 0; m_pend = 0; m_irq = 0;
        end else begin
            seq_step(0, 0, 1, 2, 8'hAA, 8'h55, cc, cdat);
            seq_step(1, 3, 4, 5, 8'h01, 8'hF4, pc, pdat);
            wk = (m_mode == 2) ? irq_act[2] : (m_mode != 0 && irq_act != 0);
            if (wk) begin
                if (m_mode == 2) m_src = src_of(m_cfg);
                m_mode = 0;
            end else if (pc && int'(pdat[7:3]) <= 4) begin
                m_mode = int'(pdat[7:3]);
                m_cd = int'(pdat[2:0]);
            end
            if (cc) m_cfg = cdat;
            m_irq = m_pend && pll_lock;
            if (m_lock_prev && !pll_lock) m_pend = 1;
            else if (pll_lock) m_pend = 0;
            m_lock_prev = pll_lock;
            m_cnt = pll_lock ? (m_cnt + 1) % 128 : 0;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            int dexp;
            dexp = 0;
            for (int i = 0; i < 5; i++) if (i >= m_mode) dexp |= (1 << i);
            chk(int'(dom_en), dexp, "R6 model dom_en");
            chk(int'(pwr_mode), m_mode, "R2 model pwr_mode");
            chk(int'(cd_sel), m_cd, "R2 model cd_sel");
            chk(int'(clk_src), m_src, "R8 model clk_src");
            chk(int'(core_halt), int'(!pll_lock), "R10 model core_halt");
            chk(int'(core_clk_en), int'(pll_lock && (m_cnt % (1 << m_cd)) == 0), "R12 model core_clk_en");
            chk(int'(pll_irq), int'(m_irq), "R11 model pll_irq");
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
            finish_run();
        end
    end

    // ---------------- stimulus helpers (called at posedge + 1) ----------------
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic pw_set(input int md, input int div);
        bus_write(3'd3, 8'h01);
        bus_write(3'd4, {md[4:0], div[2:0]});
        bus_write(3'd5, 8'hF4);
    endtask

    task automatic ck_set(input logic [7:0] v);
        bus_write(3'd0, 8'hAA);
        bus_write(3'd1, v);
        bus_write(3'd2, 8'h55);
    endtask

    task automatic irq_pulse(input logic [3:0] v);
        irq_act = v;
        @(posedge clk); #1;
        irq_act = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic nap_and_wake(input int exp_src);
        pw_set(2, 0);
        chk(int'(dom_en), 5'b11100, "R6 nap domains");
        irq_pulse(4'b0001);
        chk(int'(pwr_mode), 2, "R8 nap ignores non-timer irq");
        irq_pulse(4'b0100);
        chk(int'(pwr_mode), 0, "R8 timer wakes from nap");
        chk(int'(clk_src), exp_src, "R9 applied clock source");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(int'(pwr_mode), 0, "R1 reset mode");
        chk(int'(dom_en), 5'b11111, "R1 reset domains");
        chk(int'(cd_sel), 0, "R1 reset cd");
        chk(int'(clk_src), 0, "R1 reset clk_src");
        chk(int'(pll_irq), 0, "R1 reset pll_irq");
        idle(3);

        // Pause with CD=2, wake by irq bit 0
        pw_set(1, 2);
        chk(int'(pwr_mode), 1, "R2 pause committed");
        chk(int'(cd_sel), 2, "R2 cd committed");
        chk(int'(dom_en), 5'b11110, "R6 pause domains");
        irq_pulse(4'b0001);
        chk(int'(pwr_mode), 0, "R7 wake from pause");
        chk(int'(dom_en), 5'b11111, "R7 domains after wake");

        // Sleep, wake by bit 1; Stop, wake by bit 3
        pw_set(3, 3);
        chk(int'(dom_en), 5'b11000, "R6 sleep domains");
        irq_pulse(4'b0010);
        chk(int'(pwr_mode), 0, "R7 wake from sleep");
        pw_set(4, 1);
        chk(int'(dom_en), 5'b10000, "R6 stop domains");
        irq_pulse(4'b1000);
        chk(int'(pwr_mode), 0, "R7 wake from stop");
        chk(int'(cd_sel), 1, "R7 cd kept over wake");

        // Illegal mode code ignored
        pw_set(5, 6);
        chk(int'(pwr_mode), 0, "R5 illegal mode ignored");
        chk(int'(cd_sel), 1, "R5 cd untouched by illegal mode");
        pw_set(31, 0);
        chk(int'(cd_sel), 1, "R5 top code ignored");

        // Broken framing
        bus_write(3'd3, 8'h02); bus_write(3'd4, 8'h08); bus_write(3'd5, 8'hF4);
        chk(int'(pwr_mode), 0, "R4 wrong first key");
        bus_write(3'd3, 8'h01); bus_write(3'd0, 8'h00); bus_write(3'd4, 8'h08); bus_write(3'd5, 8'hF4);
        chk(int'(pwr_mode), 0, "R4 intervening write");
        bus_write(3'd3, 8'h01); bus_write(3'd4, 8'h08); bus_write(3'd5, 8'hF5);
        chk(int'(pwr_mode), 0, "R4 wrong second key");
        bus_write(3'd3, 8'h01); bus_write(3'd4, 8'h08); idle(2); bus_write(3'd1, 8'h00); bus_write(3'd5, 8'hF4);
        chk(int'(pwr_mode), 0, "R4 foreign write before second key");
        pw_set(1, 1);
        chk(int'(pwr_mode), 1, "R4 clean sequence after abort");
        irq_pulse(4'b0100);

        // Clock source: pending until nap wake
        ck_set(8'h01);
        chk(int'(clk_src), 0, "R3 pending not applied");
        nap_and_wake(1);
        ck_set(8'h03);
        idle(2);
        chk(int'(clk_src), 1, "R3 still old source");
        nap_and_wake(2);
        ck_set(8'h11);
        nap_and_wake(0);
        bus_write(3'd0, 8'hAA); bus_write(3'd1, 8'h03); bus_write(3'd2, 8'h54);
        nap_and_wake(0);
        chk(int'(clk_src), 0, "R4 bad clock key leaves config");

        // Divider rates
        pw_set(0, 2);
        begin
            int cnt;
            cnt = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (core_clk_en) cnt++;
            end
            chk(cnt, 4, "R12 cd=2 pulses in 16 cycles");
        end
        @(posedge clk); #1;
        pw_set(0, 0);
        idle(4);
        pw_set(0, 7);
        idle(300);

        // PLL lock loss and relock
        pw_set(0, 1);
        pll_lock = 1'b0;
        @(negedge clk);
        chk(int'(core_halt), 1, "R10 halt on lock loss");
        chk(int'(core_clk_en), 0, "R10 enable low while halted");
        idle(3);
        pll_lock = 1'b1;
        chk(int'(pll_irq), 0, "R11 no irq before relock edge");
        @(posedge clk); #1;
        chk(int'(pll_irq), 1, "R11 irq after relock");
        @(posedge clk); #1;
        chk(int'(pll_irq), 0, "R11 irq lasts one cycle");
        idle(20);

        // Wake beats a same-edge commit
        pw_set(3, 0);
        bus_write(3'd3, 8'h01); bus_write(3'd4, 8'h10);
        bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 8'hF4; irq_act = 4'b0001;
        @(posedge clk); #1;
        bus_wr = 1'b0; irq_act = '0;
        chk(int'(pwr_mode), 0, "R7 wake wins over commit");
        idle(5);

        finish_run();
    end

endmodule